// File: doc/BRIEF.md
# Variable-Length Instruction Field Parser

The parser takes a stream of instruction bytes for a classic 16-bit segmented processor encoding and splits each instruction into its fields. Every instruction starts with an opcode byte. Depending on the opcode, an addressing byte may follow, holding the addressing mode, a register number and a register-or-memory selector. Zero, one or two displacement bytes may come next, then zero, one or two immediate bytes. The number of trailing bytes is not known from the opcode alone. It is fixed only once the addressing byte has arrived: the mode field sets the displacement size and the operand-width bit sets the immediate size.

Bytes enter over a valid/ready handshake, one byte per cycle in which both `in_valid` and `in_ready` are high. `in_ready` is low while reset is held and during the first cycle after reset, and high at all other times. The parser therefore never back-pressures a running stream, and a source may present a byte in every cycle. The source may also drop `in_valid` for any number of cycles between bytes; a byte offered while `in_valid` is low is not taken. When the last byte of an instruction is taken, the decoded record appears for exactly one cycle with `out_valid`, in the cycle after that handshake. The record has no ready signal: a consumer must capture it in that cycle. The record fields are only meaningful while `out_valid` is high. The byte that follows the last byte of an instruction always starts a new instruction.

Top module: `insn_field_parser`

## Requirements
- R1: The first byte taken after reset, or after the last byte of an instruction, is the opcode and appears in `out_opcode`. `out_len` gives the total byte count of the instruction, from 1 to 6.
- R2: Every opcode outside the two addressing-byte classes of R10 is a single-byte instruction: `out_len`=1, and `out_w`, `out_d`, `out_mod` and `out_rm` are 0. `out_reg` carries opcode bits [2:0] when opcode bits [7:3] are 10010 (exchange with accumulator) and is 0 otherwise.
- R3: For the two addressing-byte classes, `out_w` is opcode bit 0. `out_d` is opcode bit 1 for the register/memory class and 0 for the immediate class.
- R4: The byte after the opcode of an addressing-byte class is split as mode = bits [7:6] (`out_mod`), register = bits [5:3] (`out_reg`) and selector = bits [2:0] (`out_rm`). In the immediate class the register bits are passed through unchanged as an opcode extension.
- R5: Mode 00 and mode 11 bring no displacement: `out_disp`=0, and a register/memory instruction is 2 bytes long.
- R6: Mode 01 brings one displacement byte, zero-extended into `out_disp`. Mode 10 brings two displacement bytes, least-significant byte first. A register/memory instruction is therefore 3 or 4 bytes long.
- R7: An immediate-class instruction has its displacement bytes (per R5/R6) followed by the immediate bytes: one byte, zero-extended into `out_imm`, when w=0, or two bytes, least-significant first, when w=1. Its length is 2 + displacement bytes + immediate bytes, so mode 10 gives 5 or 6 bytes. In every other class `out_imm` is 0.
- R8: `out_valid` is high for exactly the one cycle after the handshake of an instruction's last byte. `in_ready` is high whenever reset has been low for at least one cycle. No byte is taken while `in_valid` is low.
- R9: Synchronous reset drops any partly received instruction. While reset is held, `out_valid` and `in_ready` are low. The first byte taken after reset is an opcode.
- R10: `out_class` encodes the format: 0 = single byte; 1 = register/memory with an addressing byte (opcodes whose bits [7:6]=00 and bit [2]=0, and opcodes 0x88 to 0x8B); 2 = immediate with an addressing byte (opcodes 0x80, 0x81, 0xC6, 0xC7). The code 3 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A byte is offered on `in_byte` |
| in_ready | output | 1 | Parser accepts a byte this cycle |
| in_byte | input | 8 | Instruction stream byte |
| out_valid | output | 1 | One-cycle strobe: the record is valid |
| out_opcode | output | 8 | Opcode byte |
| out_class | output | 2 | Format class code (R10) |
| out_w | output | 1 | Operand width bit |
| out_d | output | 1 | Direction bit |
| out_mod | output | 2 | Addressing mode field |
| out_reg | output | 3 | Register field or opcode extension |
| out_rm | output | 3 | Register/memory selector field |
| out_disp | output | 16 | Displacement, zero-extended when one byte |
| out_imm | output | 16 | Immediate, zero-extended when one byte |
| out_len | output | 3 | Instruction length in bytes |

## Verification
Two things can happen in the same cycle: a finished record is strobed out, and the opcode of the next instruction is taken. When that opcode is a single-byte instruction, its own record follows at once, so strobes come back to back. The bench feeds the whole opcode space with `in_valid` held high between instructions to force this overlap. It inserts idle cycles with a stray byte on `in_byte` inside some instructions. Each strobe is matched, in order, against a queue of records computed from the byte sequence, so a record whose fields are overwritten by the next opcode, or a lost or extra strobe, shows up as a field mismatch or an unexpected strobe.

// File: rtl/ifp_pkg.sv
package ifp_pkg;
  localparam int BYTE_W      = 8;
  localparam int FIELD_BYTES = 2;
  localparam int FIELD_W     = BYTE_W * FIELD_BYTES;
  localparam int MAX_LEN     = 2 + 2 * FIELD_BYTES;
  localparam int LEN_W       = $clog2(MAX_LEN + 1);
  localparam int CNT_W       = $clog2(FIELD_BYTES + 1);
  localparam int IDX_W       = (FIELD_BYTES > 1) ? $clog2(FIELD_BYTES) : 1;
  localparam logic [4:0] XCHG_TAG = 5'b10010;

  typedef enum logic [1:0] {
    CLS_ONE       = 2'd0,
    CLS_MODRM     = 2'd1,
    CLS_MODRM_IMM = 2'd2
  } fmt_cls_e;

  typedef enum logic [1:0] {
    PH_OP, PH_MODRM, PH_DISP, PH_IMM
  } phase_e;
endpackage

// File: rtl/ifp_classify.sv
module ifp_classify
  import ifp_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode,
  output fmt_cls_e          cls
);
  always_comb begin
    if (opcode == 8'h80 || opcode == 8'h81 || opcode == 8'hC6 || opcode == 8'hC7)
      cls = CLS_MODRM_IMM;
    else if ((opcode[7:6] == 2'b00 && !opcode[2]) || opcode[7:2] == 6'b100010)
      cls = CLS_MODRM;
    else
      cls = CLS_ONE;
  end
endmodule

// File: rtl/ifp_sequencer.sv
module ifp_sequencer
  import ifp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [BYTE_W-1:0] in_byte,
  input  fmt_cls_e          cls_in,
  output logic              in_ready,
  output logic              take_op,
  output logic              take_modrm,
  output logic              take_disp,
  output logic              take_imm,
  output logic [IDX_W-1:0]  slot,
  output logic              emit
);
  phase_e             ph_q, ph_d;
  fmt_cls_e           cls_q;
  logic               w_q;
  logic [CNT_W-1:0]   rem_q, rem_d, disp_n, imm_n;
  logic [IDX_W-1:0]   slot_q, slot_d;
  logic               ready_q, emit_q, last_c;

  function automatic logic [CNT_W-1:0] disp_count(input logic [1:0] mode);
    case (mode)
      2'b01:   disp_count = CNT_W'(1);
      2'b10:   disp_count = CNT_W'(FIELD_BYTES);
      default: disp_count = '0;
    endcase
  endfunction

  assign disp_n     = disp_count(in_byte[7:6]);
  assign imm_n      = w_q ? CNT_W'(FIELD_BYTES) : CNT_W'(1);
  assign take_op    = take && (ph_q == PH_OP);
  assign take_modrm = take && (ph_q == PH_MODRM);
  assign take_disp  = take && (ph_q == PH_DISP);
  assign take_imm   = take && (ph_q == PH_IMM);
  assign slot       = slot_q;
  assign in_ready   = ready_q;
  assign emit       = emit_q;

  always_comb begin
    ph_d   = ph_q;
    rem_d  = rem_q;
    slot_d = slot_q;
    last_c = 1'b0;
    unique case (ph_q)
      PH_OP: begin
        if (cls_in == CLS_ONE) last_c = 1'b1;
        else                   ph_d   = PH_MODRM;
      end
      PH_MODRM: begin
        if (disp_n != '0) begin
          ph_d   = PH_DISP;
          rem_d  = disp_n - 1'b1;
          slot_d = '0;
        end else if (cls_q == CLS_MODRM_IMM) begin
          ph_d   = PH_IMM;
          rem_d  = imm_n - 1'b1;
          slot_d = '0;
        end else begin
          ph_d   = PH_OP;
          last_c = 1'b1;
        end
      end
      PH_DISP: begin
        if (rem_q != '0) begin
          rem_d  = rem_q - 1'b1;
          slot_d = slot_q + 1'b1;
        end else if (cls_q == CLS_MODRM_IMM) begin
          ph_d   = PH_IMM;
          rem_d  = imm_n - 1'b1;
          slot_d = '0;
        end else begin
          ph_d   = PH_OP;
          last_c = 1'b1;
        end
      end
      PH_IMM: begin
        if (rem_q != '0) begin
          rem_d  = rem_q - 1'b1;
          slot_d = slot_q + 1'b1;
        end else begin
          ph_d   = PH_OP;
          last_c = 1'b1;
        end
      end
      default: ph_d = PH_OP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_OP;
      cls_q   <= CLS_ONE;
      w_q     <= 1'b0;
      rem_q   <= '0;
      slot_q  <= '0;
      ready_q <= 1'b0;
      emit_q  <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      emit_q  <= take && last_c;
      if (take) begin
        ph_q   <= ph_d;
        rem_q  <= rem_d;
        slot_q <= slot_d;
      end
      if (take_op) begin
        cls_q <= cls_in;
        w_q   <= in_byte[0];
      end
    end
  end
endmodule

// File: rtl/ifp_assembler.sv
module ifp_assembler
  import ifp_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [BYTE_W-1:0]  in_byte,
  input  fmt_cls_e           cls_in,
  input  logic               take_op,
  input  logic               take_modrm,
  input  logic               take_disp,
  input  logic               take_imm,
  input  logic [IDX_W-1:0]   slot,
  output logic [BYTE_W-1:0]  opcode_q,
  output fmt_cls_e           cls_q,
  output logic               w_q,
  output logic               d_q,
  output logic [1:0]         mod_q,
  output logic [2:0]         reg_q,
  output logic [2:0]         rm_q,
  output logic [FIELD_W-1:0] disp_q,
  output logic [FIELD_W-1:0] imm_q,
  output logic [LEN_W-1:0]   len_q
);
  logic any_take;
  assign any_take = take_op || take_modrm || take_disp || take_imm;

  always_ff @(posedge clk) begin
    if (rst) begin
      opcode_q <= '0;
      cls_q    <= CLS_ONE;
      w_q      <= 1'b0;
      d_q      <= 1'b0;
      mod_q    <= '0;
      reg_q    <= '0;
      rm_q     <= '0;
      disp_q   <= '0;
      imm_q    <= '0;
      len_q    <= '0;
    end else begin
      if (take_op) begin
        opcode_q <= in_byte;
        cls_q    <= cls_in;
        w_q      <= (cls_in != CLS_ONE) && in_byte[0];
        d_q      <= (cls_in == CLS_MODRM) && in_byte[1];
        mod_q    <= '0;
        reg_q    <= (cls_in == CLS_ONE && in_byte[7:3] == XCHG_TAG) ? in_byte[2:0] : 3'd0;
        rm_q     <= '0;
        disp_q   <= '0;
        imm_q    <= '0;
        len_q    <= LEN_W'(1);
      end else if (any_take) begin
        len_q <= len_q + 1'b1;
      end
      if (take_modrm) begin
        mod_q <= in_byte[7:6];
        reg_q <= in_byte[5:3];
        rm_q  <= in_byte[2:0];
      end
      for (int g = 0; g < FIELD_BYTES; g++) begin
        if (take_disp && slot == IDX_W'(g)) disp_q[g*BYTE_W +: BYTE_W] <= in_byte;
        if (take_imm  && slot == IDX_W'(g)) imm_q[g*BYTE_W +: BYTE_W]  <= in_byte;
      end
    end
  end
endmodule

// File: rtl/insn_field_parser.sv
module insn_field_parser
  import ifp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_byte,
  output logic        out_valid,
  output logic [7:0]  out_opcode,
  output logic [1:0]  out_class,
  output logic        out_w,
  output logic        out_d,
  output logic [1:0]  out_mod,
  output logic [2:0]  out_reg,
  output logic [2:0]  out_rm,
  output logic [15:0] out_disp,
  output logic [15:0] out_imm,
  output logic [2:0]  out_len
);
  fmt_cls_e         cls_in, cls_rec;
  logic             take, take_op, take_modrm, take_disp, take_imm;
  logic [IDX_W-1:0] slot;

  assign take = in_valid && in_ready;

  ifp_classify u_cls (
    .opcode (in_byte),
    .cls    (cls_in)
  );

  ifp_sequencer u_seq (
    .clk        (clk),
    .rst        (rst),
    .take       (take),
    .in_byte    (in_byte),
    .cls_in     (cls_in),
    .in_ready   (in_ready),
    .take_op    (take_op),
    .take_modrm (take_modrm),
    .take_disp  (take_disp),
    .take_imm   (take_imm),
    .slot       (slot),
    .emit       (out_valid)
  );

  ifp_assembler u_asm (
    .clk        (clk),
    .rst        (rst),
    .in_byte    (in_byte),
    .cls_in     (cls_in),
    .take_op    (take_op),
    .take_modrm (take_modrm),
    .take_disp  (take_disp),
    .take_imm   (take_imm),
    .slot       (slot),
    .opcode_q   (out_opcode),
    .cls_q      (cls_rec),
    .w_q        (out_w),
    .d_q        (out_d),
    .mod_q      (out_mod),
    .reg_q      (out_reg),
    .rm_q       (out_rm),
    .disp_q     (out_disp),
    .imm_q      (out_imm),
    .len_q      (out_len)
  );

  assign out_class = cls_rec;
endmodule

// File: rtl/ifp_checker.sv
module ifp_checker (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [7:0]  in_byte,
  input logic        out_valid,
  input logic [7:0]  out_opcode,
  input logic [1:0]  out_class,
  input logic        out_w,
  input logic        out_d,
  input logic [1:0]  out_mod,
  input logic [2:0]  out_reg,
  input logic [2:0]  out_rm,
  input logic [15:0] out_disp,
  input logic [15:0] out_imm,
  input logic [2:0]  out_len
);
  logic [2:0] dcnt;
  always_comb dcnt = (out_mod == 2'b01) ? 3'd1 : (out_mod == 2'b10) ? 3'd2 : 3'd0;

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_len >= 3'd1 && out_len <= 3'd6)); // R1
  AST_ONE_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == 2'd0) |-> (out_len == 3'd1 && out_mod == 2'd0 && out_rm == 3'd0 && !out_w)); // R2
  AST_D_ONLY_REGMEM: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class != 2'd1) |-> !out_d); // R3
  AST_REGMEM_LEN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == 2'd1) |-> (out_len == 3'd2 + dcnt)); // R5
  AST_NARROW_DISP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_mod != 2'b10) |-> (out_disp[15:8] == 8'h00)); // R6
  AST_IMM_LEN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == 2'd2) |-> (out_len == 3'd3 + dcnt + {2'b00, out_w})); // R7
  AST_NARROW_IMM: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_w) |-> (out_imm[15:8] == 8'h00)); // R7
  AST_EMIT_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_ready)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!out_valid && !in_ready)); // R9
  AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_class != 2'd3)); // R10
endmodule

bind insn_field_parser ifp_checker chk_i (.*);

// File: tb/insn_field_parser_tb.sv
module insn_field_parser_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_ready, out_valid, out_w, out_d;
  logic [7:0]  out_opcode;
  logic [1:0]  out_class, out_mod;
  logic [2:0]  out_reg, out_rm, out_len;
  logic [15:0] out_disp, out_imm;

  typedef struct packed {
    logic [7:0]  op;
    logic [1:0]  cls;
    logic        w;
    logic        d;
    logic [1:0]  md;
    logic [2:0]  rg;
    logic [2:0]  rm;
    logic [15:0] disp;
    logic [15:0] imm;
    logic [2:0]  len;
  } rec_t;

  rec_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  insn_field_parser dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .out_valid(out_valid), .out_opcode(out_opcode), .out_class(out_class), .out_w(out_w),
    .out_d(out_d), .out_mod(out_mod), .out_reg(out_reg), .out_rm(out_rm),
    .out_disp(out_disp), .out_imm(out_imm), .out_len(out_len)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected out_valid", 16'd1, 16'd0);
      end else begin
        rec_t e;
        e = exp_q.pop_front();
        chk(out_opcode == e.op, "R1 opcode", {8'h0, out_opcode}, {8'h0, e.op});
        chk(out_len == e.len, "R1 length", {13'h0, out_len}, {13'h0, e.len});
        chk(out_class == e.cls, "R10 class", {14'h0, out_class}, {14'h0, e.cls});
        chk({out_w, out_d} == {e.w, e.d}, "R3 w/d", {14'h0, out_w, out_d}, {14'h0, e.w, e.d});
        chk(out_mod == e.md && out_rm == e.rm, "R4 mod/rm", {11'h0, out_mod, out_rm}, {11'h0, e.md, e.rm});
        chk(out_reg == e.rg, "R2 R4 reg", {13'h0, out_reg}, {13'h0, e.rg});
        chk(out_disp == e.disp, "R5 R6 disp", out_disp, e.disp);
        chk(out_imm == e.imm, "R7 imm", out_imm, e.imm);
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    while (!in_ready) @(negedge clk);
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    in_valid = 1'b0;
    in_byte  = 8'h90;
  endtask

  function automatic logic [1:0] class_of(input logic [7:0] op);
    if (op == 8'h80 || op == 8'h81 || op == 8'hC6 || op == 8'hC7) return 2'd2;
    if ((op[7:6] == 2'b00 && !op[2]) || op[7:2] == 6'b100010) return 2'd1;
    return 2'd0;
  endfunction

  task automatic run_insn(input logic [7:0] op, input logic [1:0] m, input bit gaps);
    logic [7:0] bytes[6];
    int n;
    rec_t e;
    logic [2:0] rg, rm;
    logic [7:0] d0, d1, i0, i1;
    int nd, ni;
    e = '0;
    e.op  = op;
    e.cls = class_of(op);
    rg = op[2:0] ^ {1'b0, m};
    rm = op[5:3] + {1'b0, m};
    d0 = op ^ 8'h5A;
    d1 = op + {6'h0, m} + 8'h11;
    i0 = ~op;
    i1 = {op[3:0], m, 2'b01};
    bytes[0] = op;
    n = 1;
    if (e.cls == 2'd0) begin
      e.rg = (op[7:3] == 5'b10010) ? op[2:0] : 3'd0;
    end else begin
      e.w  = op[0];
      e.d  = (e.cls == 2'd1) ? op[1] : 1'b0;
      e.md = m;
      e.rg = rg;
      e.rm = rm;
      bytes[1] = {m, rg, rm};
      n = 2;
      nd = (m == 2'b01) ? 1 : (m == 2'b10) ? 2 : 0;
      if (nd >= 1) begin bytes[n] = d0; n++; end
      if (nd == 2) begin bytes[n] = d1; n++; end
      e.disp = (nd == 2) ? {d1, d0} : (nd == 1) ? {8'h00, d0} : 16'h0;
      if (e.cls == 2'd2) begin
        ni = op[0] ? 2 : 1;
        bytes[n] = i0; n++;
        if (ni == 2) begin bytes[n] = i1; n++; end
        e.imm = (ni == 2) ? {i1, i0} : {8'h00, i0};
      end
    end
    e.len = 3'(n);
    for (int k = 0; k < n; k++) begin
      if (gaps && k == 1) idle_cycle();
      send_byte(bytes[k]);
    end
    exp_q.push_back(e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 reset out_valid", {15'h0, out_valid}, 16'h0);
    chk(in_ready == 1'b0, "R9 reset in_ready", {15'h0, in_ready}, 16'h0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1, "R8 ready after reset", {15'h0, in_ready}, 16'h1);

    // R8: strobe exactly one cycle after the last byte
    run_insn(8'hF8, 2'd0, 1'b0);
    idle_cycle();
    chk(out_valid == 1'b1, "R8 strobe cycle", {15'h0, out_valid}, 16'h1);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 strobe width", {15'h0, out_valid}, 16'h0);

    // Sweep all opcodes, every mode for addressing-byte classes, back to back
    for (int op = 0; op < 256; op++) begin
      if (class_of(8'(op)) == 2'd0) run_insn(8'(op), 2'd0, (op % 5) == 2);
      else for (int m = 0; m < 4; m++) run_insn(8'(op), 2'(m), ((op + m) % 3) == 1);
    end
    idle_cycle();
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all records seen", 16'(exp_q.size()), 16'h0);

    // R9: reset in the middle of a 6-byte instruction discards it
    send_byte(8'h81);
    send_byte(8'h80);
    send_byte(8'hAA);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 out_valid in reset", {15'h0, out_valid}, 16'h0);
    chk(in_ready == 1'b0, "R9 in_ready in reset", {15'h0, in_ready}, 16'h0);
    rst = 1'b0;
    @(negedge clk);
    run_insn(8'hF8, 2'd0, 1'b0);
    run_insn(8'hC7, 2'd2, 1'b0);
    run_insn(8'h88, 2'd1, 1'b1);
    idle_cycle();
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9 records after reset", 16'(exp_q.size()), 16'h0);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule